// File: doc/BRIEF.md
# Lamp Driver Overload Timing Controller

This block holds the digital timing and protection logic for a bank of low-side lamp driver channels. A free-running oscillator enable of about 50 kHz steps one shared 7-bit prescaler. Two slow timing ticks come from it: a coarse tick at one in every 128 steps (about 400 Hz) and a fine tick at one in every 8 steps (about 6.4 kHz). Each channel has its own state machine and timers. When a channel is switched on, it first asks the analog stage for a doubled current limit while the lamp filament is cold. After that window it drops to the normal limit, and at the end of a second window it checks whether current limiting is still in force.

A host loads one data bit per channel. During the check window the output stays on whatever the host writes. If the limit-active indication from the analog stage is still high when the window ends, the channel is switched off, its data bit is cleared, and a sticky fault flag is raised. Writing the bit to 1 again clears that flag and restarts the channel. A standby input stops the prescaler and turns off every output while keeping the stored bits. A power-on reset input forces everything into the off state.

Top module: `lamp_guard_top`

## Requirements
- R1: While `rst` or `por` is sampled high at a clock edge, every bit of `drv_on`, `hi_limit`, `data_q` and `fault` is 0 after that edge.
- R2: A write (`wr_en` high, `standby` low) loads `wr_data` into `data_q` at that edge. A channel whose bit became 1 while it was off raises `drv_on` at the following edge.
- R3: `hi_limit` of a channel is high only during its inrush phase. That phase starts with `drv_on` and lasts at least 128 and at most 257 clock cycles when `osc_en` is high every cycle, which is one full coarse-tick period after alignment.
- R4: After inrush, a second window of 16 fine ticks (8 oscillator steps each) follows. Across inrush and this window, `drv_on` stays 1 even when the channel's data bit is written to 0.
- R5: If `ilim_active` of a channel is 1 at the end of the second window, `drv_on` falls, `data_q` is cleared and `fault` is set at the same edge. The channel stays off until a write of 1, which also clears `fault`.
- R6: If `ilim_active` is 0 at the end of the window, the channel stays on with `hi_limit` low. A later write of 0 turns `drv_on` off at the edge after the write.
- R7: With `standby` high, every `drv_on` is 0 after the next edge, `data_q` keeps its value, and writes are ignored. Once `standby` falls, channels whose bit is 1 restart with inrush at the next edge.
- R8: The prescaler advances only on edges where `osc_en` is high and `standby` is low. Each tick lasts one clock. With `osc_en` held low, a channel in inrush does not progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-on reset, low supply; forces all off |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| standby | input | 1 | Low-power mode: prescaler halted, outputs off |
| wr_en | input | 1 | Load strobe for the data bits |
| wr_data | input | NUM_CH | New data bits, one per channel |
| ilim_active | input | NUM_CH | Current limiting in force, per channel |
| drv_on | output | NUM_CH | Power stage switched on |
| hi_limit | output | NUM_CH | Select doubled inrush current limit |
| data_q | output | NUM_CH | Stored data bits |
| fault | output | NUM_CH | Sticky overload flags |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge, so every register stage is counted. `data_q` is due one edge after a write. `drv_on` is due one edge later still, and the standby shutdown one edge after `standby`. The overload shutdown, the data clear and the fault flag all appear on the same sample. Window lengths are measured by counting falling-edge samples while an output stays high, and they are compared against bounds derived from the tick alignment.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'b00,
        ST_INRUSH = 2'b01,
        ST_LIMIT2 = 2'b10,
        ST_ON     = 2'b11
    } chan_state_e;

    typedef struct packed {
        logic fast;
        logic slow;
    } tick_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lamp_prescaler.sv
module lamp_prescaler
    import lamp_pkg::*;
#(
    parameter int PRESC_W  = 7,
    parameter int SLOW_BIT = PRESC_W - 1,
    parameter int FAST_BIT = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  osc_en,
    input  logic  standby,
    output tick_t tick
);
    logic [PRESC_W-1:0] cnt_q;
    logic [PRESC_W-1:0] prev_q;
    logic               step;

    assign step = osc_en && !standby;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= cnt_q;
            if (step) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick.slow = cnt_q[SLOW_BIT] && !prev_q[SLOW_BIT];
        tick.fast = cnt_q[FAST_BIT] && !prev_q[FAST_BIT];
    end

    assert_fast_single_R8: assert property (@(posedge clk) disable iff (rst)
        tick.fast |=> !tick.fast);
    assert_slow_single_R8: assert property (@(posedge clk) disable iff (rst)
        tick.slow |=> !tick.slow);
    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q));

endmodule

// File: rtl/lamp_channel.sv
module lamp_channel
    import lamp_pkg::*;
#(
    parameter int LIMIT2_TICKS = 16
) (
    input  logic  clk,
    input  logic  clr,
    input  logic  standby,
    input  logic  wr_en,
    input  logic  wr_bit,
    input  tick_t tick,
    input  logic  ilim,
    output logic  drv_on,
    output logic  hi_limit,
    output logic  data_q,
    output logic  fault
);
    localparam int FCW = cnt_width(LIMIT2_TICKS);
    localparam logic [FCW-1:0] FLAST = FCW'(LIMIT2_TICKS - 1);

    chan_state_e    st_q;
    logic           armed_q;
    logic [FCW-1:0] fcnt_q;
    logic           data_r;
    logic           fault_r;

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q    <= ST_OFF;
            armed_q <= 1'b0;
            fcnt_q  <= '0;
            data_r  <= 1'b0;
            fault_r <= 1'b0;
        end else begin
            if (wr_en && !standby) begin
                data_r <= wr_bit;
                if (wr_bit) fault_r <= 1'b0;
            end
            case (st_q)
                ST_OFF: begin
                    if (!standby && data_r) begin
                        st_q    <= ST_INRUSH;
                        armed_q <= 1'b0;
                        fcnt_q  <= '0;
                    end
                end
                ST_INRUSH: begin
                    if (standby) begin
                        st_q <= ST_OFF;
                    end else if (tick.slow) begin
                        if (armed_q) begin
                            st_q   <= ST_LIMIT2;
                            fcnt_q <= '0;
                        end else begin
                            armed_q <= 1'b1;
                        end
                    end
                end
                ST_LIMIT2: begin
                    if (standby) begin
                        st_q <= ST_OFF;
                    end else if (tick.fast) begin
                        if (fcnt_q == FLAST) begin
                            if (ilim) begin
                                st_q    <= ST_OFF;
                                fault_r <= 1'b1;
                                data_r  <= 1'b0;
                            end else begin
                                st_q <= ST_ON;
                            end
                        end else begin
                            fcnt_q <= fcnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (standby || !data_r) st_q <= ST_OFF;
                end
            endcase
        end
    end

    always_comb begin
        drv_on   = (st_q != ST_OFF);
        hi_limit = (st_q == ST_INRUSH);
        data_q   = data_r;
        fault    = fault_r;
    end

    assert_reset_off_R1: assert property (@(posedge clk)
        clr |=> (st_q == ST_OFF && !data_r && !fault_r));
    assert_window_hold_R4: assert property (@(posedge clk) disable iff (clr)
        (st_q == ST_INRUSH && !tick.slow && !standby) |=> (st_q == ST_INRUSH));
    assert_overload_clear_R5: assert property (@(posedge clk) disable iff (clr)
        $rose(fault_r) |-> (!data_r && !drv_on));
    assert_standby_off_R7: assert property (@(posedge clk) disable iff (clr)
        standby |=> !drv_on);
    assert_standby_keep_R7: assert property (@(posedge clk) disable iff (clr)
        standby |=> $stable(data_r));

endmodule

// File: rtl/lamp_guard_top.sv
module lamp_guard_top
    import lamp_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int PRESC_W      = 7,
    parameter int FAST_BIT     = 2,
    parameter int LIMIT2_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              osc_en,
    input  logic              standby,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] wr_data,
    input  logic [NUM_CH-1:0] ilim_active,
    output logic [NUM_CH-1:0] drv_on,
    output logic [NUM_CH-1:0] hi_limit,
    output logic [NUM_CH-1:0] data_q,
    output logic [NUM_CH-1:0] fault
);
    localparam int SLOW_BIT = PRESC_W - 1;

    logic  clr;
    tick_t tick;

    assign clr = rst || por;

    lamp_prescaler #(
        .PRESC_W (PRESC_W),
        .SLOW_BIT(SLOW_BIT),
        .FAST_BIT(FAST_BIT)
    ) u_presc (
        .clk    (clk),
        .rst    (clr),
        .osc_en (osc_en),
        .standby(standby),
        .tick   (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        lamp_channel #(
            .LIMIT2_TICKS(LIMIT2_TICKS)
        ) u_ch (
            .clk     (clk),
            .clr     (clr),
            .standby (standby),
            .wr_en   (wr_en),
            .wr_bit  (wr_data[c]),
            .tick    (tick),
            .ilim    (ilim_active[c]),
            .drv_on  (drv_on[c]),
            .hi_limit(hi_limit[c]),
            .data_q  (data_q[c]),
            .fault   (fault[c])
        );
    end

    assert_limit_implies_on_R3: assert property (@(posedge clk) disable iff (clr)
        (hi_limit & ~drv_on) == '0);

endmodule

// File: tb/lamp_guard_top_tb.sv
`timescale 1ns/1ps
module lamp_guard_top_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         por = 1'b0;
    logic         osc_en = 1'b1;
    logic         standby = 1'b0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] ilim_active = '0;
    logic [N-1:0] drv_on, hi_limit, data_q, fault;
    logic [N-1:0] dq = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    lamp_guard_top #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst(rst), .por(por), .osc_en(osc_en), .standby(standby),
        .wr_en(wr_en), .wr_data(wr_data), .ilim_active(ilim_active),
        .drv_on(drv_on), .hi_limit(hi_limit), .data_q(data_q), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive at a falling edge, captured at the next rising edge, sampled after it
    task automatic wr(input logic [N-1:0] v);
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        cyc(3);
        rst = 1'b0;
        chk(drv_on == 0 && hi_limit == 0, "R1 outputs after reset", int'(drv_on), 0);
        chk(data_q == 0 && fault == 0, "R1 latches after reset", int'(data_q), 0);
    endtask

    task automatic t_inrush();
        int n = 1;
        dq[0] = 1'b1;
        wr(dq);
        chk(data_q[0] == 1'b1, "R2 data loaded", int'(data_q[0]), 1);
        chk(drv_on[0] == 1'b0, "R2 drv not yet on", int'(drv_on[0]), 0);
        cyc(1);
        chk(drv_on[0] == 1'b1, "R2 drv on second edge", int'(drv_on[0]), 1);
        chk(hi_limit[0] == 1'b1, "R3 high limit at start", int'(hi_limit[0]), 1);
        while (hi_limit[0] && n < 400) begin
            cyc(1);
            if (hi_limit[0]) n++;
        end
        chk(n >= 128 && n <= 257, "R3 inrush length", n, 128);
        chk(drv_on[0] == 1'b1, "R4 on after inrush", int'(drv_on[0]), 1);
    endtask

    task automatic t_steady();
        cyc(140);
        chk(drv_on[0] == 1'b1 && hi_limit[0] == 1'b0, "R6 steady on, normal limit",
            int'({drv_on[0], hi_limit[0]}), 2);
        dq[0] = 1'b0;
        wr(dq);
        chk(drv_on[0] == 1'b1, "R6 still on at write edge", int'(drv_on[0]), 1);
        cyc(1);
        chk(drv_on[0] == 1'b0, "R6 off after write 0", int'(drv_on[0]), 0);
    endtask

    task automatic t_overload();
        int n = 0;
        ilim_active[1] = 1'b1;
        dq[1] = 1'b1;
        wr(dq);
        cyc(1);
        while (hi_limit[1] && n < 400) begin cyc(1); n++; end
        n = 0;
        if (drv_on[1]) n = 1;
        while (drv_on[1] && n < 400) begin
            cyc(1);
            if (drv_on[1]) n++;
        end
        chk(n >= 120 && n <= 129, "R4 second window of 16 fine ticks", n, 128);
        chk(fault[1] == 1'b1, "R5 fault set", int'(fault[1]), 1);
        chk(data_q[1] == 1'b0, "R5 data cleared", int'(data_q[1]), 0);
        dq[1] = 1'b0;
        ilim_active[1] = 1'b0;
        cyc(300);
        chk(drv_on[1] == 1'b0 && fault[1] == 1'b1, "R5 stays off, sticky",
            int'({drv_on[1], fault[1]}), 1);
        dq[1] = 1'b1;
        wr(dq);
        chk(fault[1] == 1'b0, "R5 fault cleared by write 1", int'(fault[1]), 1'b0);
        cyc(1);
        chk(drv_on[1] == 1'b1, "R5 restart after write 1", int'(drv_on[1]), 1);
    endtask

    task automatic t_window_hold();
        int n = 1;
        dq[2] = 1'b1;
        wr(dq);
        cyc(4);
        dq[2] = 1'b0;
        wr(dq);
        chk(data_q[2] == 1'b0, "R4 data written 0", int'(data_q[2]), 0);
        while (drv_on[2] && n < 500) begin
            cyc(1);
            if (drv_on[2]) n++;
        end
        chk(n >= 245 && n <= 390, "R4 output held through window", n, 300);
        chk(fault[2] == 1'b0, "R6 no fault without limiting", int'(fault[2]), 0);
    endtask

    task automatic t_standby();
        dq[3] = 1'b1;
        wr(dq);
        cyc(420);
        chk(drv_on[3] == 1'b1, "R6 channel 3 on", int'(drv_on[3]), 1);
        standby = 1'b1;
        cyc(1);
        chk(drv_on == 0, "R7 all outputs off", int'(drv_on), 0);
        chk(data_q == dq, "R7 data kept", int'(data_q), int'(dq));
        wr(dq | 8'h10);
        chk(data_q == dq, "R7 write ignored", int'(data_q), int'(dq));
        cyc(300);
        chk(drv_on == 0, "R7 stays off", int'(drv_on), 0);
        standby = 1'b0;
        cyc(1);
        chk(drv_on[3] == 1'b1 && hi_limit[3] == 1'b1, "R7 restart with inrush",
            int'({drv_on[3], hi_limit[3]}), 3);
    endtask

    task automatic t_osc_gate();
        int n = 0;
        osc_en = 1'b0;
        cyc(400);
        chk(hi_limit[3] == 1'b1, "R8 no progress without oscillator", int'(hi_limit[3]), 1);
        osc_en = 1'b1;
        while (hi_limit[3] && n < 400) begin cyc(1); n++; end
        chk(n >= 127 && n <= 258, "R8 inrush resumes", n, 128);
    endtask

    task automatic t_por();
        por = 1'b1;
        cyc(1);
        por = 1'b0;
        chk(drv_on == 0 && hi_limit == 0, "R1 por outputs off", int'(drv_on), 0);
        chk(data_q == 0 && fault == 0, "R1 por clears latches", int'(data_q), 0);
    endtask

    initial begin
        t_reset();
        t_inrush();
        t_steady();
        t_overload();
        t_window_hold();
        t_standby();
        t_osc_gate();
        t_por();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule